// File: doc/BRIEF.md
# Byte-wide erasable programmable memory emulator

A clocked, synthesizable stand-in for a byte-wide ultraviolet-erasable programmable read-only memory, meant as a target for testing a device programmer. The programmer drives an address, a data byte, active-low chip-enable and output-enable, and two logic flags. One flag stands for the programming supply being at its high level. The other stands for the raised identification voltage on address bit 9. The emulator answers on a byte-wide data output. A separate qualifier models the high-impedance state.

A programming pulse is a chip-enable low window taken while the programming supply is present and output-enable is high. The pulse is committed when chip-enable rises. Programming can only clear bits, and only the bulk-erase input sets them back to one. Each cell needs an address-dependent number of accepted pulses before its zero bits stick, so the programmer's retry loop can be exercised. A pulse that is too short is reported as a timing violation and has no effect. An identification mode returns a fixed manufacturer byte and a fixed device byte, each with odd parity.

The array depth is a parameter (`ADDR_W`); the default is kept small for elaboration, and a value of 15 gives the full 32K x 8 organisation.

Top module: `eprom_emu`

## Requirements
- R1: With the supply flag low, the identification flag low and both enables low, `dout_en_o` is 1 and `dout_o` equals the stored byte at `addr_i`, in the same cycle.
- R2: With the supply flag low and either enable high, `dout_en_o` is 0 and `dout_o` is all zeros.
- R3: A pulse is accepted when chip-enable stays low for at least `MIN_PULSE` clock edges with the supply flag high and output-enable high, and chip-enable then rises while both are still high. The stored byte then becomes old AND `din_i`, using the address and data present at the rising edge. While the pulse is running, `dout_en_o` is 0.
- R4: The cell at address a needs (a mod `PULSES_MAX`) + 1 accepted pulses before any write changes it. Earlier accepted pulses leave it unchanged. Once it has reached that count, every further accepted pulse takes effect at once.
- R5: A pulse that ends after fewer than `MIN_PULSE` low edges raises `tviol_o` for exactly one cycle, starting at the edge where chip-enable is seen high. Such a pulse changes no byte and does not add to the cell's pulse count.
- R6: With the supply flag high, chip-enable high and output-enable low, `dout_en_o` is 1 and `dout_o` shows the stored byte at `addr_i`.
- R7: With the supply flag high and both enables high, `dout_en_o` is 0 and no byte changes.
- R8: With the identification flag high, the supply flag low and both enables low, `dout_o` is 8'h97 when `addr_i[0]` is 0 and 8'h04 when it is 1, whatever the other address bits are. Each of these codes has an odd number of ones.
- R9: When `erase_i` is high at a clock edge, every byte becomes all ones and every pulse count returns to zero. Erase wins over a pulse that commits at the same edge.
- R10: After reset every byte reads as all ones, every pulse count is zero and `tviol_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | DATA_W | Byte to program |
| ce_n_i | input | 1 | Chip enable, active low; its rising edge ends a pulse |
| oe_n_i | input | 1 | Output enable, active low |
| vpp_hi_i | input | 1 | Programming supply present |
| id_hv_i | input | 1 | Identification voltage present on address bit 9 |
| erase_i | input | 1 | Bulk erase to all ones |
| dout_o | output | DATA_W | Output byte, zero when not driven |
| dout_en_o | output | 1 | Output driven (0 models high impedance) |
| tviol_o | output | 1 | One-cycle flag for a pulse that was too short |

## Verification
Two events can land on the same clock edge: a programming pulse committing on the rise of chip-enable, and a bulk erase. The bench raises chip-enable and `erase_i` at the same moment at the end of a full-length pulse on a cell that has already reached its pulse count. The reference model applies the erase only. A later read must show all ones. The cell must also need its full pulse count again, which shows that the commit was dropped and the count was cleared.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    // Source selected for the output byte
    typedef enum logic [1:0] {
        SEL_OFF    = 2'd0,
        SEL_ARRAY  = 2'd1,
        SEL_VERIFY = 2'd2,
        SEL_IDENT  = 2'd3
    } out_sel_e;

endpackage

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic vpp_hi_i,
    output logic commit_o,
    output logic viol_o
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CNT_SAT = CW'(MIN_PULSE);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic          viol;
    } pt_state_t;

    pt_state_t st_d, st_q;
    logic      prog_cond;

    always_comb begin
        st_d      = st_q;
        st_d.viol = 1'b0;
        commit_o  = 1'b0;
        prog_cond = vpp_hi_i && oe_n_i;
        if (prog_cond && !ce_n_i) begin
            // chip enable low inside program conditions: count the width
            st_d.act = 1'b1;
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (st_q.act) begin
            st_d.act = 1'b0;
            st_d.cnt = '0;
            // a pulse ends properly only on the rise of chip enable
            if (prog_cond && ce_n_i) begin
                if (st_q.cnt == CNT_SAT) begin
                    commit_o = 1'b1;
                end else begin
                    st_d.viol = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol_o = st_q.viol;

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PULSES_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HW    = $clog2(PULSES_MAX + 1);

    typedef struct packed {
        logic              en;
        logic              stick;
        logic [DATA_W-1:0] data;
        logic [HW-1:0]     hits;
    } cell_wr_t;

    logic [DATA_W-1:0] mem_q  [DEPTH];
    logic [HW-1:0]     hits_q [DEPTH];
    cell_wr_t          wr_d;
    int                need;
    int                hn;

    always_comb begin
        need       = (int'(addr_i) % PULSES_MAX) + 1;
        hn         = int'(hits_q[addr_i]) + 1;
        wr_d.en    = commit_i && !erase_i;
        wr_d.stick = (hn >= need);
        // zero bits of the new byte clear, ones leave the cell alone
        wr_d.data  = mem_q[addr_i] & din_i;
        wr_d.hits  = (hn > PULSES_MAX) ? HW'(PULSES_MAX) : HW'(hn);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || erase_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i]  <= '1;
                hits_q[i] <= '0;
            end
        end else if (wr_d.en) begin
            hits_q[addr_i] <= wr_d.hits;
            if (wr_d.stick) begin
                mem_q[addr_i] <= wr_d.data;
            end
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] MFG_CODE = 8'h97,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h04
) (
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              vpp_hi_i,
    input  logic              id_hv_i,
    input  logic              addr0_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);
    import eprom_pkg::*;

    out_sel_e sel;

    always_comb begin
        sel = SEL_OFF;
        if (!vpp_hi_i && !ce_n_i && !oe_n_i) begin
            sel = id_hv_i ? SEL_IDENT : SEL_ARRAY;
        end else if (vpp_hi_i && ce_n_i && !oe_n_i) begin
            sel = SEL_VERIFY;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ARRAY, SEL_VERIFY: dout_o = rdata_i;
            SEL_IDENT:             dout_o = addr0_i ? DEV_CODE : MFG_CODE;
            default:               dout_o = '0;
        endcase
        dout_en_o = (sel != SEL_OFF);
    end

endmodule

// File: rtl/eprom_emu.sv
module eprom_emu #(
    parameter int                ADDR_W     = 10,
    parameter int                DATA_W     = 8,
    parameter int                PULSES_MAX = 3,
    parameter int                MIN_PULSE  = 4,
    parameter logic [DATA_W-1:0] MFG_CODE   = 8'h97,
    parameter logic [DATA_W-1:0] DEV_CODE   = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              vpp_hi_i,
    input  logic              id_hv_i,
    input  logic              erase_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o,
    output logic              tviol_o
);
    logic              commit;
    logic [DATA_W-1:0] rdata;

    eprom_pulse_timer #(
        .MIN_PULSE(MIN_PULSE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_i   (ce_n_i),
        .oe_n_i   (oe_n_i),
        .vpp_hi_i (vpp_hi_i),
        .commit_o (commit),
        .viol_o   (tviol_o)
    );

    eprom_cell_array #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PULSES_MAX(PULSES_MAX)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_i  (erase_i),
        .commit_i (commit),
        .addr_i   (addr_i),
        .din_i    (din_i),
        .rdata_o  (rdata)
    );

    eprom_out_mux #(
        .DATA_W  (DATA_W),
        .MFG_CODE(MFG_CODE),
        .DEV_CODE(DEV_CODE)
    ) u_mux (
        .ce_n_i    (ce_n_i),
        .oe_n_i    (oe_n_i),
        .vpp_hi_i  (vpp_hi_i),
        .id_hv_i   (id_hv_i),
        .addr0_i   (addr_i[0]),
        .rdata_i   (rdata),
        .dout_o    (dout_o),
        .dout_en_o (dout_en_o)
    );

endmodule

// File: rtl/eprom_emu_chk.sv
module eprom_emu_chk #(
    parameter int                ADDR_W   = 10,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] MFG_CODE = 8'h97,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ce_n_i,
    input logic              oe_n_i,
    input logic              vpp_hi_i,
    input logic              id_hv_i,
    input logic              erase_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_en_o,
    input logic              tviol_o
);
    logic rd_mode;
    logic id_mode;
    assign rd_mode = !vpp_hi_i && !id_hv_i && !ce_n_i && !oe_n_i;
    assign id_mode = !vpp_hi_i && id_hv_i && !ce_n_i && !oe_n_i;

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> dout_en_o); // R1

    AST_READ_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode && $past(rd_mode) && $stable(addr_i) && !$past(erase_i))
        |-> ((dout_o & ~$past(dout_o)) == '0)); // R1

    AST_DISABLED_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi_i && (ce_n_i || oe_n_i)) |-> (!dout_en_o && dout_o == '0)); // R2

    AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi_i && oe_n_i) |-> !dout_en_o); // R3

    AST_VIOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tviol_o |=> !tviol_o); // R5

    AST_VIOL_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tviol_o) |-> $past(ce_n_i) && !$past(ce_n_i, 2)); // R5

    AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi_i && ce_n_i && !oe_n_i) |-> dout_en_o); // R6

    AST_IDENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        id_mode |-> (dout_en_o && dout_o == (addr_i[0] ? DEV_CODE : MFG_CODE))); // R8

    AST_IDENT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        id_mode |-> (^dout_o)); // R8

    AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(erase_i) && rd_mode) |-> (dout_o == '1)); // R9

endmodule

bind eprom_emu eprom_emu_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MFG_CODE(MFG_CODE),
    .DEV_CODE(DEV_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .ce_n_i    (ce_n_i),
    .oe_n_i    (oe_n_i),
    .vpp_hi_i  (vpp_hi_i),
    .id_hv_i   (id_hv_i),
    .erase_i   (erase_i),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o),
    .tviol_o   (tviol_o)
);

// File: tb/eprom_emu_bench.sv
module eprom_emu_bench;
    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int PMAX  = 3;
    localparam int MINP  = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] din_i = '0;
    logic          ce_n_i = 1'b1;
    logic          oe_n_i = 1'b1;
    logic          vpp_hi_i = 1'b0;
    logic          id_hv_i = 1'b0;
    logic          erase_i = 1'b0;
    logic [DW-1:0] dout_o;
    logic          dout_en_o;
    logic          tviol_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    int            ref_hit [DEPTH];

    always #5 clk = ~clk;

    eprom_emu #(
        .ADDR_W(AW), .DATA_W(DW), .PULSES_MAX(PMAX), .MIN_PULSE(MINP),
        .MFG_CODE(8'h97), .DEV_CODE(8'h04)
    ) u_eprom_emu (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
        .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .vpp_hi_i(vpp_hi_i),
        .id_hv_i(id_hv_i), .erase_i(erase_i), .dout_o(dout_o),
        .dout_en_o(dout_en_o), .tviol_o(tviol_o)
    );

    function automatic int need_of(int a);
        return (a % PMAX) + 1;
    endfunction

    function automatic logic [DW-1:0] ident_of(logic a0);
        return a0 ? 8'h04 : 8'h97;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ref_erase();
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = '1;
            ref_hit[i] = 0;
        end
    endtask

    task automatic do_read(input int a);
        @(negedge clk);
        vpp_hi_i = 0; id_hv_i = 0; ce_n_i = 0; oe_n_i = 0; addr_i = AW'(a);
        #1;
        check(dout_en_o === 1'b1 && dout_o === ref_mem[a], "R1 read",
              {dout_en_o, dout_o}, {1'b1, ref_mem[a]});
    endtask

    task automatic do_disabled(input int a, input bit ce, input bit oe);
        @(negedge clk);
        vpp_hi_i = 0; id_hv_i = $urandom % 2; ce_n_i = ce; oe_n_i = oe; addr_i = AW'(a);
        #1;
        check(dout_en_o === 1'b0 && dout_o === '0, "R2 disabled",
              {dout_en_o, dout_o}, 0);
    endtask

    task automatic do_verify(input int a);
        @(negedge clk);
        vpp_hi_i = 1; id_hv_i = 0; ce_n_i = 1; oe_n_i = 0; addr_i = AW'(a);
        #1;
        check(dout_en_o === 1'b1 && dout_o === ref_mem[a], "R6 verify",
              {dout_en_o, dout_o}, {1'b1, ref_mem[a]});
    endtask

    task automatic do_ident(input int a);
        logic [DW-1:0] e;
        e = ident_of(a[0]);
        @(negedge clk);
        vpp_hi_i = 0; id_hv_i = 1; ce_n_i = 0; oe_n_i = 0; addr_i = AW'(a);
        #1;
        check(dout_en_o === 1'b1 && dout_o === e && (^dout_o) === 1'b1, "R8 ident",
              {dout_en_o, dout_o}, {1'b1, e});
    endtask

    task automatic do_erase();
        @(negedge clk);
        vpp_hi_i = 0; id_hv_i = 0; ce_n_i = 1; oe_n_i = 1; erase_i = 1;
        @(negedge clk);
        erase_i = 0;
        ref_erase();
    endtask

    // One programming pulse of len low edges; er raises erase with the rising edge
    task automatic do_prog(input int a, input logic [DW-1:0] d, input int len, input bit er);
        int hn;
        @(negedge clk);
        vpp_hi_i = 1; id_hv_i = 0; oe_n_i = 1; ce_n_i = 1; addr_i = AW'(a); din_i = d;
        @(negedge clk);
        ce_n_i = 0;
        #1;
        check(dout_en_o === 1'b0, "R3 quiet during pulse", dout_en_o, 0);
        repeat (len) @(negedge clk);
        ce_n_i = 1; erase_i = er;
        @(negedge clk);
        erase_i = 0;
        #1;
        check(tviol_o === (len < MINP && !er ? 1'b1 : (len < MINP ? 1'b1 : 1'b0)),
              "R5 violation flag", tviol_o, len < MINP);
        check(dout_en_o === 1'b0, "R7 inhibit hiz", dout_en_o, 0);
        @(negedge clk);
        #1;
        check(tviol_o === 1'b0, "R5 one cycle", tviol_o, 0);
        vpp_hi_i = 0;
        if (er) begin
            ref_erase();
        end else if (len >= MINP) begin
            hn = ref_hit[a] + 1;
            if (hn >= need_of(a)) ref_mem[a] = ref_mem[a] & d;
            ref_hit[a] = (hn > PMAX) ? PMAX : hn;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        ref_erase();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: blank after reset
        @(negedge clk);
        #1;
        check(tviol_o === 1'b0, "R10 reset flag", tviol_o, 0);
        do_read(0);
        do_read(DEPTH - 1);
        do_read(123);
        check(dout_o === 8'hFF, "R10 reset blank", dout_o, 8'hFF);

        // R3/R4: address 0 needs one pulse, bits only clear
        do_prog(0, 8'hA5, MINP, 0);
        do_read(0);
        do_prog(0, 8'h0F, MINP, 0);
        do_read(0);
        check(dout_o === 8'h05, "R3 and-only", dout_o, 8'h05);
        do_prog(0, 8'hFF, MINP, 0);
        do_read(0);
        check(dout_o === 8'h05, "R3 ones ignored", dout_o, 8'h05);

        // R4/R5: address 5 needs three; a short pulse does not count
        do_prog(5, 8'h3C, MINP - 1, 0);
        do_read(5);
        do_prog(5, 8'h3C, MINP, 0);
        do_read(5);
        do_prog(5, 8'h3C, MINP, 0);
        do_read(5);
        check(dout_o === 8'hFF, "R4 not yet", dout_o, 8'hFF);
        do_prog(5, 8'h3C, MINP, 0);
        do_read(5);
        check(dout_o === 8'h3C, "R4 third pulse sticks", dout_o, 8'h3C);
        do_prog(5, 8'h18, MINP + 3, 0);
        do_verify(5);
        check(dout_o === 8'h18, "R4 after count immediate", dout_o, 8'h18);

        // R7: inhibit leaves array unchanged
        @(negedge clk);
        vpp_hi_i = 1; ce_n_i = 1; oe_n_i = 1; addr_i = 5; din_i = 8'h00;
        repeat (3) @(negedge clk);
        do_verify(5);
        check(dout_o === 8'h18, "R7 inhibit no change", dout_o, 8'h18);

        // R8: other address bits ignored
        do_ident(0);
        do_ident(1);
        do_ident(DEPTH - 2);
        do_ident(DEPTH - 1);

        // R9: erase and commit on the same edge, erase wins
        do_prog(0, 8'h00, MINP, 1);
        do_read(0);
        check(dout_o === 8'hFF, "R9 erase wins", dout_o, 8'hFF);
        do_read(5);
        do_prog(5, 8'h00, MINP, 0);
        do_read(5);
        check(dout_o === 8'hFF, "R9 count cleared", dout_o, 8'hFF);

        // random mix on a small pool of addresses plus full range
        for (int it = 0; it < 400; it++) begin
            int op;
            int a;
            op = $urandom % 8;
            a  = ($urandom % 4 == 0) ? int'($urandom % DEPTH) : int'($urandom % 12);
            case (op)
                0, 1, 2: do_prog(a, DW'($urandom), 1 + int'($urandom % (MINP + 2)), 0);
                3:       do_read(a);
                4:       do_verify(a);
                5:       do_ident(a);
                6:       do_disabled(a, $urandom % 2 == 1, 1'b1);
                default: if ($urandom % 10 == 0) do_erase(); else do_disabled(a, 1'b1, $urandom % 2 == 1);
            endcase
        end
        for (int a = 0; a < 12; a++) do_read(a);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule